// File: doc/BRIEF.md
# UART Buffering and Flag Status Unit

This block provides the transmit and receive storage of a serial port, together with a read-only status word that describes that storage. A mode input chooses how deep the storage is. In queued mode, each direction holds up to `DEPTH` bytes, first in, first out. In single-slot mode, each direction holds exactly one byte. The empty and full flags follow whichever kind of storage is active.

A register bus pushes transmit bytes by writing the data offset. Reading the data offset pops the oldest received byte. The receiver delivers bytes through a valid strobe. A transmit shifter takes bytes from the transmit storage, but only while the port is enabled. Each byte goes out as one start bit, eight data bits LSB first, and one or two stop bits. Each bit lasts from one baud tick to the next. The busy flag covers the whole time that transmit work exists, whether it is still stored or still being shifted out.

Top module: `uart_buf_flags`

## Requirements
- R1: After reset, the status word at offset 0x018 reads 0x90: the transmit-empty and receive-empty flags are 1, and the transmit-full, receive-full and busy flags are 0.
- R2: The status word places transmit-empty at bit 7, receive-full at bit 6, transmit-full at bit 5, receive-empty at bit 4 and busy at bit 3. Bits 31:8 and 2:0 always read 0.
- R3: When `fifo_en`=1, each direction holds up to 16 bytes in arrival order. A transmit write at offset 0x000 while 16 bytes are queued is dropped.
- R4: When `fifo_en`=0, each direction holds exactly one byte. The full flag sets after one byte, and a second transmit write is dropped.
- R5: Busy becomes 1 in the cycle after a transmit byte is stored, even when `uart_en`=0.
- R6: Busy stays 1 until the final stop bit of the last byte has ended, and no byte is still waiting. With `two_stop`=1, this is one baud tick later than with one stop bit.
- R7: A frame on `txd` is: one 0 start bit, the 8 data bits LSB first, then 1 stop bit (`two_stop`=0) or 2 stop bits (`two_stop`=1). Each bit advances on a `baud_tick`. The line rests at 1 when idle.
- R8: While `uart_en`=0, no frame starts and `txd` stays 1.
- R9: Writes to offset 0x018 change nothing.
- R10: A change of `fifo_en` empties both directions. The status word then reads transmit-empty=1 and receive-empty=1.
- R11: A read at offset 0x000 returns the oldest received byte in bits 7:0 and removes it. A read while the receive side is empty returns 0 and leaves the status word unchanged.
- R12: A received byte that arrives while the receive side is full is dropped. `rx_overrun` then pulses for one cycle, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_en | input | 1 | Port enable; allows the shifter to load |
| fifo_en | input | 1 | 1 = queued mode, 0 = single-slot mode |
| two_stop | input | 1 | 1 = two stop bits per frame |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data; bits 7:0 form the transmit byte |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial transmit line |
| rx_overrun | output | 1 | Pulse when a received byte is dropped |

## Verification
The bench fills each direction exactly to its limit in both modes, then pushes one more byte. A wrong capacity shows up as an early or late full flag, or as an extra byte that appears in the read order or on the line. It writes data while the port is disabled. A shifter that ignored the enable would start a frame, and a busy flag tied to shifting alone would stay 0. It samples busy just before and just after the final stop bit, with one and with two stop bits. A design that cleared busy at the start of the stop bit or ignored the second stop bit would be caught there. It also toggles the mode with bytes stored on both sides and reads an empty receive side, which catches a missing flush and a pop that corrupts the flags.

// File: rtl/uart_buf_flags.sv
module uart_buf_flags #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  parameter int AW = 12,
  parameter int BW = 32,
  parameter logic [11:0] DATA_OFS = 12'h000,
  parameter logic [11:0] FLAG_OFS = 12'h018
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uart_en,
  input  logic          fifo_en,
  input  logic          two_stop,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          baud_tick,
  output logic          txd,
  output logic          rx_overrun
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int FW  = DW + 3;
  localparam int BCW = $clog2(FW + 1);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, cap;
  logic          mode_q, flush;
  logic [FW-1:0] sh_reg;
  logic [BCW-1:0] sh_left;
  logic          sh_act;

  logic sel_data, sel_flag;
  logic tx_empty, tx_full, rx_empty, rx_full, busy;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic [BW-1:0] flags;
  logic unused_wdata;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  assign flush    = fifo_en != mode_q;
  assign sel_data = bus_addr == AW'(DATA_OFS);
  assign sel_flag = bus_addr == AW'(FLAG_OFS);

  assign tx_empty = tx_cnt == '0;
  assign rx_empty = rx_cnt == '0;
  assign tx_full  = tx_cnt >= cap;
  assign rx_full  = rx_cnt >= cap;
  assign busy     = !tx_empty || sh_act;

  assign tx_push = bus_wr && sel_data && !tx_full && !flush;
  assign tx_pop  = !sh_act && uart_en && !tx_empty && !flush;
  assign rx_push = rx_valid && !rx_full && !flush;
  assign rx_pop  = bus_rd && sel_data && !rx_empty && !flush;

  assign flags = {{(BW-8){1'b0}}, tx_empty, rx_full, tx_full, rx_empty, busy, 3'b000};
  assign unused_wdata = &{1'b0, bus_wdata[BW-1:DW]};

  always_comb begin
    bus_rdata = '0;
    if (sel_flag)
      bus_rdata = flags;
    else if (sel_data && !rx_empty)
      bus_rdata = {{(BW-DW){1'b0}}, rx_mem[rx_rp]};
  end

  assign txd = !sh_act || sh_reg[0];

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[DW-1:0];
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= fifo_en;
      tx_cnt <= '0; tx_wp <= '0; tx_rp <= '0;
      rx_cnt <= '0; rx_wp <= '0; rx_rp <= '0;
      rx_overrun <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      rx_overrun <= rx_valid && rx_full && !flush;
      if (flush) begin
        tx_cnt <= '0; tx_wp <= '0; tx_rp <= '0;
        rx_cnt <= '0; rx_wp <= '0; rx_rp <= '0;
      end else begin
        if (tx_push) tx_wp <= nxt(tx_wp);
        if (tx_pop)  tx_rp <= nxt(tx_rp);
        tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
        if (rx_push) rx_wp <= nxt(rx_wp);
        if (rx_pop)  rx_rp <= nxt(rx_rp);
        rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_act  <= 1'b0;
      sh_reg  <= '1;
      sh_left <= '0;
    end else if (tx_pop) begin
      sh_act  <= 1'b1;
      sh_reg  <= {2'b11, tx_mem[tx_rp], 1'b0};
      sh_left <= two_stop ? BCW'(FW) : BCW'(FW - 1);
    end else if (sh_act && baud_tick) begin
      sh_reg  <= {1'b1, sh_reg[FW-1:1]};
      sh_left <= sh_left - 1'b1;
      if (sh_left == BCW'(1)) sh_act <= 1'b0;
    end
  end

  assert_tx_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (tx_cnt <= cap && rx_cnt <= cap));
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_flag |-> (bus_rdata[BW-1:8] == '0 && bus_rdata[2:0] == 3'b000));
  assert_busy_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> bus_rdata[3] || !sel_flag);
  assert_idle_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_load_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_act) |-> $past(uart_en));
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_cnt == '0 && rx_cnt == '0));
  assert_overrun_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !flush && !rx_pop) |=> (rx_overrun && $stable(rx_cnt)));
endmodule

// File: tb/tb_uart_buf_flags.sv
module tb_uart_buf_flags;
  logic clk = 0, rst_n = 0;
  logic uart_en = 0, fifo_en = 0, two_stop = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = 12'h018;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 0, baud_tick = 0, txd, rx_overrun;
  logic [7:0] rx_data = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_buf_flags dut (.clk, .rst_n, .uart_en, .fifo_en, .two_stop, .bus_wr, .bus_rd,
    .bus_addr, .bus_wdata, .bus_rdata, .rx_valid, .rx_data, .baud_tick, .txd, .rx_overrun);

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic get_flags(output logic [31:0] v);
    @(negedge clk); #1 v = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 12'h018;
  endtask

  task automatic rd_data(output logic [31:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = 12'h000; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_addr = 12'h018;
  endtask

  task automatic rx_push(input logic [7:0] b, output logic ovr);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0; #1 ovr = rx_overrun;
  endtask

  task automatic tx_frame(input logic [7:0] b, input int nstop, input bit last, input string rq);
    logic [10:0] got = '1, exp;
    int nb = 9 + nstop;
    int w = 0;
    exp = {2'b11, b, 1'b0};
    if (nstop == 1) exp[10] = 1'b1;
    #1;
    while (txd !== 1'b0 && w < 20) begin @(negedge clk); #1; w++; end
    for (int k = 0; k < nb; k++) begin
      got[k] = txd;
      if (k == nb - 1) check({rq, " busy before last stop ends (R6)"}, 32'(bus_rdata[3]), 32'd1);
      baud_tick = 1; @(negedge clk); baud_tick = 0; #1;
    end
    check({rq, " frame bits (R7)"}, 32'(got), 32'(exp));
    if (last) check({rq, " busy clears after final stop (R6)"}, 32'(bus_rdata[3]), 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] f;
    get_flags(f);
    check("R1 reset flags", f, 32'h90);
    check("R2 reserved bits zero", {f[31:8], 5'b0, f[2:0]}, 32'h0);
  endtask

  task automatic t_hold_tx();
    logic [31:0] f;
    wr(12'h000, 32'hA5);
    get_flags(f); check("R4/R5 single slot full, busy while disabled", f, 32'h38);
    wr(12'h000, 32'h11);
    wr(12'h018, 32'hFFFF_FFFF);
    get_flags(f); check("R9 flag write ignored", f, 32'h38);
    repeat (6) @(negedge clk);
    check("R8 line idle while disabled", 32'(txd), 32'd1);
    uart_en = 1;
    tx_frame(8'hA5, 1, 1, "hold one stop");
    get_flags(f); check("R4 second write dropped", f, 32'h90);
    two_stop = 1;
    wr(12'h000, 32'h3C);
    tx_frame(8'h3C, 2, 1, "hold two stop");
    two_stop = 0;
  endtask

  task automatic t_hold_rx();
    logic [31:0] f, v; logic o;
    rx_push(8'h55, o); check("R12 no overrun on accept", 32'(o), 32'd0);
    get_flags(f); check("R4 rx single slot full", f, 32'hC0);
    rx_push(8'h66, o); check("R12 overrun pulse", 32'(o), 32'd1);
    @(negedge clk); #1 check("R12 overrun is one cycle", 32'(rx_overrun), 32'd0);
    rd_data(v); check("R11 read oldest byte", v, 32'h55);
    rd_data(v); check("R11 empty read returns 0", v, 32'h0);
    get_flags(f); check("R11 flags unchanged by empty read", f, 32'h90);
  endtask

  task automatic t_flush();
    logic [31:0] f; logic o;
    uart_en = 0;
    rx_push(8'h77, o);
    wr(12'h000, 32'h12);
    get_flags(f); check("R4 both slots held", f, 32'h68);
    @(negedge clk); fifo_en = 1;
    get_flags(f); check("R10 mode change flushes", f, 32'h90);
  endtask

  task automatic t_fifo_rx();
    logic [31:0] f, v; logic o;
    for (int i = 0; i < 15; i++) rx_push(8'(i * 7 + 1), o);
    get_flags(f); check("R3 rx 15 of 16 not full", f, 32'h80);
    rx_push(8'(15 * 7 + 1), o); check("R12 16th accepted", 32'(o), 32'd0);
    get_flags(f); check("R3 rx full at 16", f, 32'hC0);
    rx_push(8'hF0, o); check("R12 17th overruns", 32'(o), 32'd1);
    for (int i = 0; i < 16; i++) begin
      rd_data(v); check($sformatf("R3 rx order %0d", i), v, 32'(8'(i * 7 + 1)));
    end
    get_flags(f); check("R11 rx drained", f, 32'h90);
  endtask

  task automatic t_fifo_tx();
    logic [31:0] f;
    uart_en = 0;
    for (int i = 0; i < 15; i++) wr(12'h000, 32'(8'(i * 13 + 3)));
    get_flags(f); check("R3 tx 15 of 16 not full", f, 32'h18);
    wr(12'h000, 32'(8'(15 * 13 + 3)));
    get_flags(f); check("R3 tx full at 16", f, 32'h38);
    wr(12'h000, 32'hEE);
    @(negedge clk); uart_en = 1;
    for (int i = 0; i < 16; i++) tx_frame(8'(i * 13 + 3), 1, i == 15, $sformatf("fifo byte %0d R3", i));
    get_flags(f); check("R3 17th write dropped", f, 32'h90);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_hold_tx();
    t_hold_rx();
    t_flush();
    t_fifo_rx();
    t_fifo_tx();
    finish_run();
  end
endmodule